// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides whether a conditional relative branch is taken. It also produces the address where execution continues. Each request carries four inputs:
- a 4-bit condition code;
- the current negative, zero, overflow and carry flags;
- the address of the instruction that follows the branch;
- an 8-bit signed displacement.

The block sign-extends the displacement and adds it to the fall-through address, with wraparound modulo 2^16. When the condition is met, that sum is the resume address. Otherwise the fall-through address is returned unchanged.

The condition set has sixteen entries:
- always and never;
- a clear and a set test on each single flag;
- unsigned higher and lower-or-same;
- signed greater-or-equal, less-than, greater-than and less-or-equal.

The unsigned higher-or-same and lower tests are the carry-clear and carry-set codes under second names. Codes are arranged in pairs: the odd code of each pair is the exact complement of the even one. The branch-never code therefore acts as a no-operation that costs the same time as a taken branch.

A branch occupies a fixed number of cycles, `LAT` (default 3), whatever its outcome. A request presented in one cycle is answered in cycle `LAT`, counting the request cycle as cycle 1. A new request may start in every cycle.

Top module: `bce_branch_unit`

## Requirements
- R1: While reset (`rst_n` low) is held and on the first cycle after it, `rsp_valid`, `rsp_taken` and `rsp_pc` are all zero.
- R2: A request with `req_valid` high is answered by `rsp_valid` high exactly `LAT-1` clock edges after the edge that samples it. This holds whether or not the branch is taken, and back-to-back requests give back-to-back responses in order.
- R3: Carry tests: code 4 (carry clear, also unsigned higher-or-same) is taken when C=0; code 5 (carry set, also unsigned lower) is taken when C=1. The flags input is ordered N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R4: Zero and sign tests: code 6 (not equal) is taken when Z=0, code 7 (equal) when Z=1, code 10 (plus) when N=0, code 11 (minus) when N=1.
- R5: Overflow tests: code 8 is taken when V=0, code 9 when V=1.
- R6: Code 0 is always taken; code 1 is never taken, and its response returns the fall-through address.
- R7: Unsigned tests: code 2 (higher) is taken when C and Z are both 0; code 3 (lower-or-same) is taken when C=1 or Z=1.
- R8: Signed tests: code 12 (greater-or-equal) is taken when N equals V; code 13 (less-than) when N differs from V; code 14 (greater-than) when Z=0 and N equals V; code 15 (less-or-equal) when Z=1 or N differs from V.
- R9: A taken branch returns `req_pc` plus the displacement sign-extended to 16 bits, modulo 2^16.
- R10: A branch that is not taken returns `req_pc` unchanged.
- R11: For any flags, the code with bit 0 set gives the opposite decision to the same code with bit 0 clear.
- R12: In a cycle where `rsp_valid` is low, `rsp_taken` is 0 and `rsp_pc` is 0, whatever the request fields held while `req_valid` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A branch request is present this cycle |
| req_cond | input | 4 | Condition code, 0 to 15 |
| req_flags | input | 4 | Flags {N, Z, V, C} |
| req_pc | input | 16 | Address of the instruction after the branch |
| req_ofs | input | 8 | Signed branch displacement |
| rsp_valid | output | 1 | Result of the request from `LAT-1` edges earlier |
| rsp_taken | output | 1 | The condition was met |
| rsp_pc | output | 16 | Resume address |

## Verification
Every one of the sixteen codes is applied against all sixteen flag combinations, back to back. This separates each relational test from its neighbours: higher from greater-than, less-or-equal from lower-or-same. It also shows the odd/even complement for every flag pattern. Gapped traffic with junk fields on idle cycles distinguishes a true response from pipeline leakage and confirms the fixed latency. The displacements 0x00, 0x7F, 0x80 and 0xFF, at addresses near both ends of the space, separate correct sign extension and wraparound from zero extension or a carry out of 16 bits.

// File: rtl/bce_pkg.sv
package bce_pkg;

   typedef enum logic [3:0] {
      BC_ALWAYS = 4'd0,
      BC_NEVER  = 4'd1,
      BC_HI     = 4'd2,
      BC_LS     = 4'd3,
      BC_CC     = 4'd4,
      BC_CS     = 4'd5,
      BC_NE     = 4'd6,
      BC_EQ     = 4'd7,
      BC_VC     = 4'd8,
      BC_VS     = 4'd9,
      BC_PL     = 4'd10,
      BC_MI     = 4'd11,
      BC_GE     = 4'd12,
      BC_LT     = 4'd13,
      BC_GT     = 4'd14,
      BC_LE     = 4'd15
   } bcond_e;

   // second names sharing an encoding
   localparam logic [3:0] BC_HS = 4'd4;
   localparam logic [3:0] BC_LO = 4'd5;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
   import bce_pkg::*;
#(
   parameter int STYLE = 1   // 0: flat sixteen-way decode, 1: pair base + invert
) (
   input  logic [3:0] cond,
   input  flags_t     flags,
   output logic       taken
);

   logic sgn_lt;
   assign sgn_lt = flags.n ^ flags.v;

   generate
      if (STYLE == 0) begin : g_flat
         always_comb begin
            unique case (bcond_e'(cond))
               BC_ALWAYS: taken = 1'b1;
               BC_NEVER:  taken = 1'b0;
               BC_HI:     taken = ~(flags.c | flags.z);
               BC_LS:     taken = flags.c | flags.z;
               BC_CC:     taken = ~flags.c;
               BC_CS:     taken = flags.c;
               BC_NE:     taken = ~flags.z;
               BC_EQ:     taken = flags.z;
               BC_VC:     taken = ~flags.v;
               BC_VS:     taken = flags.v;
               BC_PL:     taken = ~flags.n;
               BC_MI:     taken = flags.n;
               BC_GE:     taken = ~sgn_lt;
               BC_LT:     taken = sgn_lt;
               BC_GT:     taken = ~(flags.z | sgn_lt);
               BC_LE:     taken = flags.z | sgn_lt;
               default:   taken = 1'b0;
            endcase
         end
      end else begin : g_pair
         logic base;
         always_comb begin
            unique case (cond[3:1])
               3'd0:    base = 1'b1;
               3'd1:    base = ~(flags.c | flags.z);
               3'd2:    base = ~flags.c;
               3'd3:    base = ~flags.z;
               3'd4:    base = ~flags.v;
               3'd5:    base = ~flags.n;
               3'd6:    base = ~sgn_lt;
               3'd7:    base = ~(flags.z | sgn_lt);
               default: base = 1'b0;
            endcase
         end
         assign taken = base ^ cond[0];
      end
   endgenerate

endmodule

// File: rtl/bce_target_add.sv
module bce_target_add #(
   parameter int PC_W  = 16,
   parameter int OFS_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFS_W-1:0] ofs,
   output logic [PC_W-1:0]  target
);

   localparam int EXT_W = PC_W - OFS_W;

   logic [PC_W-1:0] ofs_ext;

   generate
      if (EXT_W == 0) begin : g_noext
         assign ofs_ext = ofs;
      end else begin : g_sext
         assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
      end
   endgenerate

   // carry out of the top bit is dropped: modulo 2^PC_W
   assign target = pc + ofs_ext;

endmodule

// File: rtl/bce_pipe.sv
module bce_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] st [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) st[i] <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/bce_branch_unit.sv
module bce_branch_unit
   import bce_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int OFS_W      = 8,
   parameter int LAT        = 3,
   parameter int COND_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_cond,
   input  logic [3:0]        req_flags,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [OFS_W-1:0]  req_ofs,
   output logic              rsp_valid,
   output logic              rsp_taken,
   output logic [PC_W-1:0]   rsp_pc
);

   localparam int DEP = LAT - 1;
   localparam int PW  = PC_W + 2;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("bce_branch_unit: LAT must be at least 1");
      end
      if (OFS_W < 2 || OFS_W > PC_W) begin : g_bad_ofs
         $error("bce_branch_unit: OFS_W must lie in 2..PC_W");
      end
      if (COND_STYLE < 0 || COND_STYLE > 1) begin : g_bad_style
         $error("bce_branch_unit: COND_STYLE must be 0 or 1");
      end
   endgenerate

   flags_t          fl;
   logic            hit;
   logic [PC_W-1:0] tgt;
   logic [PC_W-1:0] resume;
   logic [PW-1:0]   stage_in;
   logic [PW-1:0]   stage_out;

   assign fl = flags_t'(req_flags);

   bce_cond_eval #(.STYLE(COND_STYLE)) u_cond (
      .cond  (req_cond),
      .flags (fl),
      .taken (hit)
   );

   bce_target_add #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
      .pc     (req_pc),
      .ofs    (req_ofs),
      .target (tgt)
   );

   assign resume   = hit ? tgt : req_pc;
   assign stage_in = req_valid ? {1'b1, hit, resume} : '0;

   bce_pipe #(.W(PW), .DEPTH(DEP)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stage_in),
      .q     (stage_out)
   );

   assign rsp_valid = stage_out[PW-1];
   assign rsp_taken = stage_out[PW-2];
   assign rsp_pc    = stage_out[PC_W-1:0];

endmodule

// File: rtl/bce_checker.sv
module bce_checker
   import bce_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int OFS_W = 8,
   parameter int LAT   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [3:0]        req_cond,
   input logic [3:0]        req_flags,
   input logic [PC_W-1:0]   req_pc,
   input logic [OFS_W-1:0]  req_ofs,
   input logic              rsp_valid,
   input logic              rsp_taken,
   input logic [PC_W-1:0]   rsp_pc
);

   localparam int DEP = LAT - 1;
   localparam int HW  = 1 + 4 + 4 + PC_W + OFS_W;

   logic [HW-1:0]    now_req;
   logic [HW-1:0]    old_req;
   logic             h_v;
   logic [3:0]       h_cond;
   logic [3:0]       h_fl;
   logic [PC_W-1:0]  h_pc;
   logic [OFS_W-1:0] h_ofs;
   logic [PC_W-1:0]  h_sum;

   assign now_req = {req_valid, req_cond, req_flags, req_pc, req_ofs};

   generate
      if (DEP == 0) begin : g_now
         assign old_req = now_req;
      end else begin : g_hist
         logic [HW-1:0] hist [DEP];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEP; i++) hist[i] <= '0;
            end else begin
               hist[0] <= now_req;
               for (int i = 1; i < DEP; i++) hist[i] <= hist[i-1];
            end
         end
         assign old_req = hist[DEP-1];
      end
   endgenerate

   assign {h_v, h_cond, h_fl, h_pc, h_ofs} = old_req;
   assign h_sum = h_pc + PC_W'($signed(h_ofs));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == h_v);

   assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond[3:1] == 3'd2) |-> (rsp_taken == (h_fl[0] == h_cond[0])));

   assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond[3:1] == 3'd3) |-> (rsp_taken == (h_fl[2] == h_cond[0])));

   assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond[3:1] == 3'd5) |-> (rsp_taken == (h_fl[3] == h_cond[0])));

   assert_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond[3:1] == 3'd4) |-> (rsp_taken == (h_fl[1] == h_cond[0])));

   assert_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond == 4'd1) |-> (!rsp_taken && rsp_pc == h_pc));

   assert_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond == 4'd0) |-> rsp_taken);

   assert_signed_ge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && h_cond == 4'd12) |-> (rsp_taken == (h_fl[3] == h_fl[1])));

   assert_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_taken) |-> (rsp_pc == h_sum));

   assert_fallthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_taken) |-> (rsp_pc == h_pc));

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_taken && rsp_pc == '0));

endmodule

bind bce_branch_unit bce_checker #(.PC_W(PC_W), .OFS_W(OFS_W), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cond  (req_cond),
   .req_flags (req_flags),
   .req_pc    (req_pc),
   .req_ofs   (req_ofs),
   .rsp_valid (rsp_valid),
   .rsp_taken (rsp_taken),
   .rsp_pc    (rsp_pc)
);

// File: tb/tb_bce_branch_unit.sv
module tb_bce_branch_unit;

   localparam int LAT = 3;
   localparam int DEP = LAT - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_cond = '0;
   logic [3:0]  req_flags = '0;
   logic [15:0] req_pc = '0;
   logic [7:0]  req_ofs = '0;
   logic        rsp_valid;
   logic        rsp_taken;
   logic [15:0] rsp_pc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit          v;
      bit          t;
      logic [15:0] pc;
      int          cond;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   bce_branch_unit #(.LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cond(req_cond),
      .req_flags(req_flags), .req_pc(req_pc), .req_ofs(req_ofs),
      .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_pc(rsp_pc)
   );

   // decision from the requirement text, flags {N,Z,V,C}
   function automatic bit ref_taken(int c, logic [3:0] f);
      bit n = f[3], z = f[2], v = f[1], cy = f[0];
      case (c)
         0:  return 1;                   // R6
         1:  return 0;                   // R6
         2:  return !cy && !z;           // R7
         3:  return cy || z;             // R7
         4:  return !cy;                 // R3
         5:  return cy;                  // R3
         6:  return !z;                  // R4
         7:  return z;                   // R4
         8:  return !v;                  // R5
         9:  return v;                   // R5
         10: return !n;                  // R4
         11: return n;                   // R4
         12: return n == v;              // R8
         13: return n != v;              // R8
         14: return !z && (n == v);      // R8
         default: return z || (n != v);  // R8
      endcase
   endfunction

   function automatic string cond_tag(int c);
      if (c < 2) return "R6/R11";
      if (c < 4) return "R7/R11";
      if (c < 6) return "R3/R11";
      if (c < 8 || c == 10 || c == 11) return "R4/R11";
      if (c < 10) return "R5/R11";
      return "R8/R11";
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model: one entry per sampling edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
      end else begin
         exp_t e;
         int   d;
         e.v    = req_valid;
         e.cond = int'(req_cond);
         e.t    = req_valid && ref_taken(int'(req_cond), req_flags);
         d      = int'($signed(req_ofs));
         e.pc   = !req_valid ? 16'h0 : (e.t ? 16'(int'(req_pc) + d) : req_pc);
         q.push_back(e);
         if (q.size() > 8) void'(q.pop_front());
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         exp_t e;
         if (q.size() >= DEP && DEP > 0) e = q[q.size() - DEP];
         else if (DEP == 0) begin
            e.v = req_valid; e.t = 0; e.pc = '0; e.cond = 0;
         end else begin
            e.v = 0; e.t = 0; e.pc = '0; e.cond = 0;
         end
         if (DEP > 0) begin
            check(rsp_valid == e.v, "R2", "rsp_valid", rsp_valid, e.v);
            if (!e.v) begin
               check(!rsp_taken && rsp_pc == 16'h0, "R12", "idle outputs",
                     {rsp_taken, rsp_pc}, 0);
            end else begin
               check(rsp_taken == e.t, cond_tag(e.cond), "rsp_taken", rsp_taken, e.t);
               check(rsp_pc == e.pc, e.t ? "R9" : "R10", "rsp_pc", rsp_pc, e.pc);
            end
         end
      end
   end

   task automatic drive(bit v, int c, int f, int pc, int ofs);
      @(negedge clk);
      req_valid = v;
      req_cond  = 4'(c);
      req_flags = 4'(f);
      req_pc    = 16'(pc);
      req_ofs   = 8'(ofs);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: outputs zero during reset, junk on the request side
      req_valid = 1'b1; req_cond = 4'd0; req_pc = 16'h1234; req_ofs = 8'h10;
      repeat (3) @(negedge clk);
      check(!rsp_valid && !rsp_taken && rsp_pc == 16'h0, "R1", "reset outputs",
            {rsp_valid, rsp_taken, rsp_pc}, 0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rsp_valid && !rsp_taken && rsp_pc == 16'h0, "R1", "first cycle after reset",
            {rsp_valid, rsp_taken, rsp_pc}, 0);

      // every code against every flag pattern, back to back (R3..R8, R11)
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            drive(1, c, f, int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)));

      // gapped traffic with junk while idle (R2, R12)
      for (int i = 0; i < 40; i++) begin
         drive(1, i % 16, (i * 7) % 16, int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)));
         drive(0, 0, 15, 16'hBEEF, 8'h55);
         if (i % 5 == 0) drive(0, 0, 0, 16'hFFFF, 8'h7F);
      end

      // displacement and wraparound boundaries (R9), and never returns fall-through (R6)
      drive(1, 0, 0, 16'hFFF0, 8'h7F);   // -> 006F
      drive(1, 0, 0, 16'h0005, 8'h80);   // -> FF85
      drive(1, 0, 0, 16'h0000, 8'hFF);   // -> FFFF
      drive(1, 0, 0, 16'h4321, 8'h00);   // -> 4321
      drive(1, 0, 0, 16'h1000, 8'h7F);   // -> 107F
      drive(1, 0, 0, 16'h8000, 8'h80);   // -> 7F80
      drive(1, 1, 0, 16'hFFF0, 8'h7F);   // never: 0xFFF0 (R10)

      // isolated request: latency seen alone (R2)
      drive(0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0);
      drive(1, 14, 0, 16'h2000, 8'hF0);  // signed greater-than, taken -> 1FF0
      drive(0, 0, 0, 0, 0);

      repeat (LAT + 3) drive(0, 0, 0, 0, 0);
      finish_run();
   end

endmodule